// File: doc/BRIEF.md
# Completion interrupt aggregator

The block gathers transfer-completion codes that a DMA engine returns and records each one as a bit in a shared 64-bit pending vector. Software reads that vector as two 32-bit words and acknowledges bits by writing ones to a clear word. The block serves four shadow regions. Each region has its own 64-bit enable mask, which is changed through separate set and clear words, and its own 64-bit access mask. Together the two masks decide which pending bits may interrupt that region.

Each region drives a single-cycle interrupt pulse. A pulse is issued when a bit becomes pending, enabled and allowed for that region at the same time. Bits that remain in that condition raise no further pulses. Before it leaves its handler, software can write the region's evaluate bit. If anything that region may see is still pending, a fresh pulse follows.

Each region owns a small pulse state machine with three states. IDLE drives the output low and waits for a trigger; IDLE goes to FIRE on a trigger and stays in IDLE otherwise. FIRE drives the output high for exactly one cycle; FIRE goes to OWED when another trigger arrives in that cycle and goes to IDLE otherwise. OWED drives the output low for one cycle and then always goes to FIRE. This is how a trigger that coincides with a pulse is delivered later instead of being lost.

Top module: `cmpl_irq_hub`

## Requirements
- R1: A strobe on `cc_valid` with code n sets pending bit n. The pending vector reads as word 0 at address 0x00 (bits 31:0) and word 1 at address 0x01 (bits 63:32), so bit n appears as bit n%32 of word n/32.
- R2: A write to address 0x02 (bits 31:0) or 0x03 (bits 63:32) clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R3: Region r uses word addresses starting at 8+8r. The enable mask reads at +0/+1. Writing ones to +2/+3 sets enable bits. Writing ones to +4/+5 clears enable bits. The access mask is written and read at +6/+7. In each pair, the first address holds bits 31:0 and the second holds bits 63:32.
- R4: When a completion strobe and a clear of the same bit arrive in one cycle, the bit ends up set.
- R5: A pending bit can raise region r's interrupt only if the bit is set in both region r's enable mask and region r's access mask.
- R6: When a bit becomes pending, enabled and allowed for a region, `irq_o[r]` is high during the second cycle after the strobe's capture edge. A bit that stays pending raises no further pulse on its own, including when its code is strobed again.
- R7: Writing 1 to bit r at address 0x04 makes `irq_o[r]` pulse two cycles after the write edge, provided that region has any bit that is pending, enabled and allowed.
- R8: An evaluate write when the region has no bit that is pending, enabled and allowed produces no pulse. Address 0x04 always reads 0.
- R9: A completion strobe and an evaluate write for the same region in the same cycle produce exactly one pulse.
- R10: Reset clears every pending, enable and access bit and holds all `irq_o` bits low.
- R11: Each pulse lasts exactly one cycle, so `irq_o[r]` is never high in two consecutive cycles. A trigger that arrives while a pulse is high is delivered as a second pulse after one low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register word address |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| cc_valid | input | 1 | Completion code strobe |
| cc_code | input | 6 | Returned completion code |
| irq_o | output | 4 | Per-region interrupt pulse |

## Verification
Register updates take effect at the capture edge, so the bench reads them back at the falling edge that follows the write. A new pending bit is registered once at the capture edge, and its rise is registered once more in the pulse state machine. The same two edges apply to an evaluate write, which is delayed by one register so that it lines up with a simultaneous strobe. The bench therefore expects the output low at the first falling edge after the capture and high at the second. Requirements that are checked by counting pulses read a falling-edge pulse counter only after several idle cycles, by which point every pulse that could be due has appeared.

// File: rtl/cih_pkg.sv
package cih_pkg;

    // Pulse generator states, one machine per region
    typedef enum logic [1:0] {
        IRQ_IDLE = 2'd0,
        IRQ_FIRE = 2'd1,
        IRQ_OWED = 2'd2
    } irq_state_e;

endpackage

// File: rtl/cih_pending.sv
module cih_pending #(
    parameter int CODE_W   = 6,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int CLR_ADDR = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_vld,
    input  logic [CODE_W-1:0]       set_code,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [(1<<CODE_W)-1:0]  pend_o
);
    localparam int NBITS  = 1 << CODE_W;
    localparam int NWORDS = NBITS / WORD_W;

    logic [NBITS-1:0] set_mask;
    logic [NBITS-1:0] clr_mask;
    logic [NBITS-1:0] pend_q;

    always_comb begin
        set_mask = '0;
        if (set_vld) begin
            set_mask[set_code] = 1'b1;
        end
    end

    always_comb begin
        clr_mask = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (bus_we && (bus_addr == ADDR_W'(CLR_ADDR + w))) begin
                clr_mask[w*WORD_W +: WORD_W] = bus_wdata;
            end
        end
    end

    // The set mask is applied after the clear mask, so a set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | set_mask;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/cih_pulse_fsm.sv
module cih_pulse_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic irq
);
    import cih_pkg::*;

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: state_d = trig ? IRQ_FIRE : IRQ_IDLE;
            IRQ_FIRE: state_d = trig ? IRQ_OWED : IRQ_IDLE;
            IRQ_OWED: state_d = IRQ_FIRE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq = (state_q == IRQ_FIRE);
    end

endmodule

// File: rtl/cih_region.sv
module cih_region #(
    parameter int CODE_W = 6,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8,
    parameter int BASE   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [WORD_W-1:0]       bus_wdata,
    input  logic                    eval_hit,
    input  logic [(1<<CODE_W)-1:0]  pend_i,
    output logic [(1<<CODE_W)-1:0]  en_o,
    output logic [(1<<CODE_W)-1:0]  acc_o,
    output logic                    irq_o
);
    localparam int NBITS   = 1 << CODE_W;
    localparam int NWORDS  = NBITS / WORD_W;
    localparam int OFS_SET = NWORDS;
    localparam int OFS_CLR = 2 * NWORDS;
    localparam int OFS_ACC = 3 * NWORDS;

    logic [NBITS-1:0]  en_q;
    logic [NBITS-1:0]  acc_q;
    logic [NBITS-1:0]  en_set;
    logic [NBITS-1:0]  en_clr;
    logic [NWORDS-1:0] acc_we;
    logic [NBITS-1:0]  act;
    logic [NBITS-1:0]  act_prev_q;
    logic              eval_q;
    logic              rise;
    logic              trig;

    always_comb begin
        en_set = '0;
        en_clr = '0;
        acc_we = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (bus_we && (bus_addr == ADDR_W'(BASE + OFS_SET + w))) begin
                en_set[w*WORD_W +: WORD_W] = bus_wdata;
            end
            if (bus_we && (bus_addr == ADDR_W'(BASE + OFS_CLR + w))) begin
                en_clr[w*WORD_W +: WORD_W] = bus_wdata;
            end
            if (bus_we && (bus_addr == ADDR_W'(BASE + OFS_ACC + w))) begin
                acc_we[w] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            acc_q <= '0;
        end else begin
            en_q <= (en_q & ~en_clr) | en_set;
            for (int w = 0; w < NWORDS; w++) begin
                if (acc_we[w]) begin
                    acc_q[w*WORD_W +: WORD_W] <= bus_wdata;
                end
            end
        end
    end

    // Bits this region may see, and their rising edges
    assign act = pend_i & en_q & acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_prev_q <= '0;
            eval_q     <= 1'b0;
        end else begin
            act_prev_q <= act;
            eval_q     <= eval_hit;
        end
    end

    // The evaluate request is delayed one cycle so it lines up with a
    // strobe in the same cycle and merges into a single trigger
    assign rise = |(act & ~act_prev_q);
    assign trig = rise | (eval_q & (|act));

    cih_pulse_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig),
        .irq   (irq_o)
    );

    assign en_o  = en_q;
    assign acc_o = acc_q;

endmodule

// File: rtl/cmpl_irq_hub.sv
module cmpl_irq_hub #(
    parameter int NREG   = 4,
    parameter int CODE_W = 6,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic               cc_valid,
    input  logic [CODE_W-1:0]  cc_code,
    output logic [NREG-1:0]    irq_o
);
    localparam int NBITS   = 1 << CODE_W;
    localparam int NWORDS  = NBITS / WORD_W;
    localparam int A_PEND  = 0;
    localparam int A_CLR   = NWORDS;
    localparam int A_EVAL  = 2 * NWORDS;
    localparam int A_RBASE = 4 * NWORDS;
    localparam int RSTRIDE = 4 * NWORDS;
    localparam int OFS_ACC = 3 * NWORDS;

    logic [NBITS-1:0] pend_vec;
    logic [NBITS-1:0] en_all  [NREG];
    logic [NBITS-1:0] acc_all [NREG];
    logic [NREG-1:0]  eval_hit;

    cih_pending #(
        .CODE_W   (CODE_W),
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W),
        .CLR_ADDR (A_CLR)
    ) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vld   (cc_valid),
        .set_code  (cc_code),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend_o    (pend_vec)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        assign eval_hit[r] = bus_we && (bus_addr == ADDR_W'(A_EVAL)) && bus_wdata[r];

        cih_region #(
            .CODE_W (CODE_W),
            .WORD_W (WORD_W),
            .ADDR_W (ADDR_W),
            .BASE   (A_RBASE + r * RSTRIDE)
        ) u_region (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_we    (bus_we),
            .bus_addr  (bus_addr),
            .bus_wdata (bus_wdata),
            .eval_hit  (eval_hit[r]),
            .pend_i    (pend_vec),
            .en_o      (en_all[r]),
            .acc_o     (acc_all[r]),
            .irq_o     (irq_o[r])
        );
    end

    // Read mux; clear, set, clear-enable and evaluate words read as 0
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (bus_addr == ADDR_W'(A_PEND + w)) begin
                bus_rdata = pend_vec[w*WORD_W +: WORD_W];
            end
        end
        for (int r = 0; r < NREG; r++) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (bus_addr == ADDR_W'(A_RBASE + r * RSTRIDE + w)) begin
                    bus_rdata = en_all[r][w*WORD_W +: WORD_W];
                end
                if (bus_addr == ADDR_W'(A_RBASE + r * RSTRIDE + OFS_ACC + w)) begin
                    bus_rdata = acc_all[r][w*WORD_W +: WORD_W];
                end
            end
        end
    end

endmodule

// File: rtl/cih_checker.sv
module cih_checker #(
    parameter int NREG   = 4,
    parameter int CODE_W = 6,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [WORD_W-1:0]      bus_wdata,
    input logic                   cc_valid,
    input logic [CODE_W-1:0]      cc_code,
    input logic [NREG-1:0]        irq_o,
    input logic [(1<<CODE_W)-1:0] pend_q,
    input logic [WORD_W-1:0]      en0_lo
);
    localparam int NWORDS = (1 << CODE_W) / WORD_W;
    localparam int A_CLR  = NWORDS;
    localparam int R0_SET = 4 * NWORDS + NWORDS;
    localparam int R0_CLR = 4 * NWORDS + 2 * NWORDS;

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RST_QUIET: assert (irq_o == '0) else $error("irq during reset"); // R10
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_chk
        AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[r] |=> !irq_o[r]); // R11
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid |=> pend_q[$past(cc_code)]); // R4

    AST_W1C_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(A_CLR) && !cc_valid)
        |=> ((pend_q[WORD_W-1:0] & $past(bus_wdata)) == '0)); // R2

    AST_W1C_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(A_CLR + 1) && !cc_valid)
        |=> ((pend_q[2*WORD_W-1:WORD_W] & $past(bus_wdata)) == '0)); // R2

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(R0_SET))
        |=> ((en0_lo & $past(bus_wdata)) == $past(bus_wdata))); // R3

    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(R0_CLR))
        |=> ((en0_lo & $past(bus_wdata)) == '0)); // R3

endmodule

bind cmpl_irq_hub cih_checker #(
    .NREG   (NREG),
    .CODE_W (CODE_W),
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .cc_valid  (cc_valid),
    .cc_code   (cc_code),
    .irq_o     (irq_o),
    .pend_q    (pend_vec),
    .en0_lo    (en_all[0][WORD_W-1:0])
);

// File: tb/sim_cmpl_irq_hub.sv
module sim_cmpl_irq_hub;

    localparam logic [7:0] PEND_LO = 8'h00;
    localparam logic [7:0] PEND_HI = 8'h01;
    localparam logic [7:0] CLR_LO  = 8'h02;
    localparam logic [7:0] CLR_HI  = 8'h03;
    localparam logic [7:0] EVAL    = 8'h04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cc_valid = 1'b0;
    logic [5:0]  cc_code = '0;
    logic [3:0]  irq_o;

    int checks = 0;
    int errors = 0;
    int pulses [4];
    int dbl = 0;
    logic [3:0] irq_prev = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmpl_irq_hub u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cc_valid  (cc_valid),
        .cc_code   (cc_code),
        .irq_o     (irq_o)
    );

    always @(negedge clk) begin
        for (int r = 0; r < 4; r++) begin
            if (irq_o[r]) begin
                pulses[r]++;
                if (irq_prev[r]) dbl++;
            end
        end
        irq_prev = irq_o;
    end

    function automatic logic [7:0] rbase(input int r);
        return 8'(8 + 8 * r);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic strobe(input logic [5:0] code);
        @(negedge clk);
        cc_valid = 1'b1; cc_code = code;
        @(negedge clk);
        cc_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R10", "irq after reset", 32'(irq_o), 32'h0);
        rd(PEND_LO, d); chk("R10", "pend lo", d, 32'h0);
        rd(PEND_HI, d); chk("R10", "pend hi", d, 32'h0);
        rd(rbase(0), d); chk("R10", "enable r0 lo", d, 32'h0);
        rd(rbase(1) + 8'd7, d); chk("R10", "access r1 hi", d, 32'h0);
    endtask

    task automatic t_first_pulse;
        logic [31:0] d;
        wr(rbase(0) + 8'd6, 32'hFFFF_FFFF);
        wr(rbase(0) + 8'd7, 32'hFFFF_FFFF);
        wr(rbase(0) + 8'd2, 32'h0000_0008);
        wr(rbase(0) + 8'd3, 32'h0000_0100);
        strobe(6'd3);
        chk("R6", "irq0 one cycle after capture", 32'(irq_o[0]), 32'h0);
        @(negedge clk);
        chk("R6", "irq0 two cycles after capture", 32'(irq_o[0]), 32'h1);
        @(negedge clk);
        chk("R11", "irq0 drops after one cycle", 32'(irq_o[0]), 32'h0);
        rd(PEND_LO, d); chk("R1", "pend lo bit 3", d, 32'h0000_0008);
    endtask

    task automatic t_no_repeat;
        int b = pulses[0];
        strobe(6'd3);
        idle(5);
        chk("R6", "repeat code no pulse", 32'(pulses[0] - b), 32'h0);
    endtask

    task automatic t_high_word;
        logic [31:0] d;
        int b = pulses[0];
        strobe(6'd40);
        idle(4);
        rd(PEND_HI, d); chk("R1", "pend hi bit 8", d, 32'h0000_0100);
        chk("R6", "pulse for code 40", 32'(pulses[0] - b), 32'h1);
    endtask

    task automatic t_eval;
        int b1 = pulses[1];
        wr(EVAL, 32'h1);
        chk("R7", "irq0 one cycle after eval", 32'(irq_o[0]), 32'h0);
        @(negedge clk);
        chk("R7", "irq0 two cycles after eval", 32'(irq_o[0]), 32'h1);
        idle(4);
        chk("R7", "region1 untouched by eval", 32'(pulses[1] - b1), 32'h0);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        wr(CLR_LO, 32'h0);
        rd(PEND_LO, d); chk("R2", "zero clear keeps lo", d, 32'h0000_0008);
        wr(CLR_LO, 32'h0000_0008);
        rd(PEND_LO, d); chk("R2", "clear bit 3", d, 32'h0);
        rd(PEND_HI, d); chk("R2", "hi kept", d, 32'h0000_0100);
        wr(CLR_HI, 32'h0000_0100);
        rd(PEND_HI, d); chk("R2", "clear hi bit 8", d, 32'h0);
    endtask

    task automatic t_eval_empty;
        logic [31:0] d;
        int b = pulses[0];
        wr(EVAL, 32'hF);
        idle(5);
        chk("R8", "eval with nothing pending", 32'(pulses[0] - b), 32'h0);
        rd(EVAL, d); chk("R8", "eval reads 0", d, 32'h0);
    endtask

    task automatic t_enable_setclr;
        logic [31:0] d;
        wr(rbase(2) + 8'd2, 32'h0000_00F0);
        wr(rbase(2) + 8'd4, 32'h0000_0030);
        rd(rbase(2), d); chk("R3", "enable r2 lo", d, 32'h0000_00C0);
        rd(rbase(2) + 8'd1, d); chk("R3", "enable r2 hi", d, 32'h0);
        wr(rbase(2) + 8'd6, 32'hA5A5_A5A5);
        rd(rbase(2) + 8'd6, d); chk("R3", "access r2 lo", d, 32'hA5A5_A5A5);
    endtask

    task automatic t_region_gate;
        int b0, b1, b2, b3;
        wr(rbase(1) + 8'd2, 32'h0000_0060);
        wr(rbase(1) + 8'd6, 32'h0000_0040);
        b0 = pulses[0]; b1 = pulses[1]; b2 = pulses[2]; b3 = pulses[3];
        strobe(6'd5);
        idle(5);
        chk("R5", "code 5 blocked r1", 32'(pulses[1] - b1), 32'h0);
        chk("R5", "code 5 not enabled r0", 32'(pulses[0] - b0), 32'h0);
        strobe(6'd6);
        idle(5);
        chk("R5", "code 6 reaches r1", 32'(pulses[1] - b1), 32'h1);
        chk("R5", "code 6 blocked r2", 32'(pulses[2] - b2), 32'h0);
        chk("R5", "r3 silent", 32'(pulses[3] - b3), 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        strobe(6'd9);
        @(negedge clk);
        cc_valid = 1'b1; cc_code = 6'd9;
        bus_addr = CLR_LO; bus_we = 1'b1; bus_wdata = 32'h0000_0200;
        @(negedge clk);
        cc_valid = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        rd(PEND_LO, d); chk("R4", "set beats clear bit 9", (d >> 9) & 32'h1, 32'h1);
        wr(CLR_LO, 32'hFFFF_FFFF);
        wr(CLR_HI, 32'hFFFF_FFFF);
        rd(PEND_LO, d); chk("R2", "all clear lo", d, 32'h0);
    endtask

    task automatic t_merge;
        int b;
        strobe(6'd40);
        idle(4);
        b = pulses[0];
        @(negedge clk);
        cc_valid = 1'b1; cc_code = 6'd3;
        bus_addr = EVAL; bus_we = 1'b1; bus_wdata = 32'h1;
        @(negedge clk);
        cc_valid = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        idle(6);
        chk("R9", "strobe plus eval one pulse", 32'(pulses[0] - b), 32'h1);
        wr(CLR_LO, 32'hFFFF_FFFF);
        wr(CLR_HI, 32'hFFFF_FFFF);
    endtask

    task automatic t_spacing;
        int b = pulses[0];
        int d0 = dbl;
        @(negedge clk);
        cc_valid = 1'b1; cc_code = 6'd3;
        @(negedge clk);
        cc_code = 6'd40;
        @(negedge clk);
        cc_valid = 1'b0;
        idle(6);
        chk("R11", "two back-to-back triggers two pulses", 32'(pulses[0] - b), 32'h2);
        chk("R11", "no two-cycle high", 32'(dbl - d0), 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_first_pulse();
        t_no_repeat();
        t_high_word();
        t_eval();
        t_clear();
        t_eval_empty();
        t_enable_setclr();
        t_region_gate();
        t_set_wins();
        t_merge();
        t_spacing();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule